// File: doc/BRIEF.md
# Requester-ID to Stream-ID Translation Table

This block sits in a PCIe root-complex wrapper. It turns the 16-bit requester ID (bus, device, function) of an inbound transaction into a 6-bit stream ID and a 3-bit domain ID. An IOMMU and an interrupt translation unit use that stream ID. The table has a parameterised number of entries, 32 by default. Each entry holds a valid flag, a domain ID, a stream ID, a reference requester ID and a 16-bit compare mask.

Software never touches an entry directly. It fills a pair of staging registers and then writes a control register that names an entry index. That write either commits the staging pair into the entry, or, when a load flag is set, copies the entry into the staging pair so it can be read. The lookup port takes one requester ID every cycle and returns a registered hit, stream ID and domain ID one cycle later. The first (lowest-index) valid entry whose masked compare succeeds decides the result.

Top module: `rid_sid_xlate`

## Requirements
- R1: After reset, every entry is invalid: every lookup misses, and the control, attribute and key registers read as zero.
- R2: The attribute register (address 1) holds the valid flag in bit 31, the domain ID in bits [10:8] and the stream ID in bits [5:0]. All its other bits read as zero, whatever was written to them.
- R3: A write to the control register (address 0) with bit 16 clear commits the staging pair into the entry selected by bits [4:0]. The control register then reads back that index, with bit 16 clear.
- R4: A write to the control register with bit 16 set copies the selected entry into the attribute and key registers. The control register then reads back the index with bit 16 set.
- R5: An entry matches a requester ID when it is valid and ((rid XOR entry_rid) AND entry_mask) is zero. A mask of 0xFFFF demands an exact match, and cleared mask bits are don't-care.
- R6: When several valid entries match, the entry with the lowest index supplies the stream and domain IDs.
- R7: When no entry matches, lk_hit is 0 and both lk_sid and lk_dom are 0.
- R8: The lookup result appears on the outputs one clock after lk_rid is presented. A lookup presented in the same cycle as a commit sees the table as it was before the commit, and the new entry takes part from the next cycle on.
- R9: Committing zero in both staging registers to an index invalidates that entry, so requester IDs it used to match fall through to later entries or miss.
- R10: The key register (address 2) holds the requester ID in bits [31:16] and the mask in bits [15:0]. Address 3 reads as zero, and writes to it change no register.
- R11: Register read data appears on reg_rdata one clock after reg_re and is zero in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register word address: 0 control, 1 attribute, 2 key |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Register read data, one cycle after reg_re |
| lk_rid | input | 16 | Requester ID to translate |
| lk_hit | output | 1 | A valid entry matched the previous cycle's lk_rid |
| lk_sid | output | 6 | Stream ID of the winning entry, zero on miss |
| lk_dom | output | 3 | Domain ID of the winning entry, zero on miss |

## Verification
The bench programs overlapping entries: a wide bus-wide mask at a low index and an exact entry at a higher index. It then probes requester IDs on both sides of each mask boundary. A priority encoder that picks the highest index, or a compare that ignores the mask, shows up as a wrong stream ID on the shared requester ID or as a false hit just outside a range. An entry that holds a matching requester ID but has its valid bit clear catches a design that skips the valid check. A lookup issued in the same cycle as a commit catches a design that forwards the new entry early. Invalidating the low entry must expose the higher one, and a read-back through the load flag must return every field in its documented bit position.

// File: rtl/rsx_pkg.sv
// Package: shared entry type, register addresses and field positions for
// the requester-ID translation table.
// Assumes: 16-bit requester IDs, 6-bit stream IDs, 3-bit domain IDs.
package rsx_pkg;

    localparam int RID_W = 16;
    localparam int SID_W = 6;
    localparam int DOM_W = 3;

    // Register word addresses.
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_ATTR = 2'd1;
    localparam logic [1:0] A_KEY  = 2'd2;

    // Field positions.
    localparam int CTRL_LOAD_BIT = 16;
    localparam int ATTR_VLD_BIT  = 31;
    localparam int ATTR_DOM_LSB  = 8;
    localparam int ATTR_SID_LSB  = 0;
    localparam int KEY_RID_LSB   = 16;
    localparam int KEY_MSK_LSB   = 0;

    typedef struct packed {
        logic             vld;
        logic [DOM_W-1:0] dom;
        logic [SID_W-1:0] sid;
        logic [RID_W-1:0] rid;
        logic [RID_W-1:0] msk;
    } rsx_entry_t;

endpackage

// File: rtl/rsx_table.sv
// Module: entry storage for the translation table.
// Holds NUM_ENTRIES entries. Accepts one write per cycle and exposes every
// entry to the matcher, plus one indexed read port for the staging load.
// Assumes: the writer keeps wr_idx below NUM_ENTRIES.
module rsx_table
    import rsx_pkg::*;
#(
    parameter  int NUM_ENTRIES = 32,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  rsx_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output rsx_entry_t       rd_entry,
    output rsx_entry_t       entries_o [NUM_ENTRIES]
);

    rsx_entry_t ent_q [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        // Purpose: hold one entry; clear on reset, replace on an indexed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ent_q[g] <= wr_entry;
            end
        end
        assign entries_o[g] = ent_q[g];
    end

    // Purpose: indexed read for the staging load; out-of-range reads give zero.
    always_comb begin
        rd_entry = '0;
        if (32'(rd_idx) < NUM_ENTRIES) rd_entry = ent_q[rd_idx];
    end

    // A committed entry must be stored exactly as presented.
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_q[$past(wr_idx)] == $past(wr_entry))
        else $error("p_write_lands_r3");

endmodule

// File: rtl/rsx_match.sv
// Module: masked parallel compare and lowest-index priority select.
// Registers hit, stream ID and domain ID one cycle after lk_rid, computed
// from the table contents before any same-edge write.
// Assumes: entries_o of rsx_table drive entries.
module rsx_match
    import rsx_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RID_W-1:0] lk_rid,
    input  rsx_entry_t       entries [NUM_ENTRIES],
    output logic             hit_o,
    output logic [SID_W-1:0] sid_o,
    output logic [DOM_W-1:0] dom_o
);

    logic [NUM_ENTRIES-1:0] hit_vec;
    logic                   any_hit;
    logic [SID_W-1:0]       sel_sid;
    logic [DOM_W-1:0]       sel_dom;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = entries[g].vld &&
                            (((lk_rid ^ entries[g].rid) & entries[g].msk) == '0);
    end

    // Purpose: pick the lowest matching index (a descending scan, so lower indices overwrite).
    always_comb begin
        any_hit = 1'b0;
        sel_sid = '0;
        sel_dom = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                sel_sid = entries[i].sid;
                sel_dom = entries[i].dom;
            end
        end
    end

    // Purpose: register the lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_o <= 1'b0;
            sid_o <= '0;
            dom_o <= '0;
        end else begin
            hit_o <= any_hit;
            sid_o <= sel_sid;
            dom_o <= sel_dom;
        end
    end

    p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (sid_o == '0 && dom_o == '0))
        else $error("p_miss_zero_r7");

    p_hit_needs_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(|hit_vec))
        else $error("p_hit_needs_match_r5");

    p_entry0_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vec[0] |=> (hit_o && sid_o == $past(entries[0].sid)
                        && dom_o == $past(entries[0].dom)))
        else $error("p_entry0_wins_r6");

endmodule

// File: rtl/rsx_regs.sv
// Module: control register and staging pair for indirect table access.
// A control write with the load flag copies an entry into staging; without
// it, the staging pair is committed to the table. Reads are registered.
// Assumes: IDX_W does not exceed 16 (the index stays below the load flag).
module rsx_regs
    import rsx_pkg::*;
#(
    parameter  int NUM_ENTRIES = 32,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [31:0]      reg_wdata,
    input  logic             reg_re,
    output logic [31:0]      reg_rdata,
    output logic             tbl_wr_en,
    output logic [IDX_W-1:0] tbl_wr_idx,
    output rsx_entry_t       tbl_wr_entry,
    output logic [IDX_W-1:0] tbl_rd_idx,
    input  rsx_entry_t       tbl_rd_entry
);

    logic             wr_ctrl, wr_attr, wr_key, load_req;
    logic [IDX_W-1:0] ctrl_idx_q;
    logic             ctrl_load_q;
    rsx_entry_t       stage_q;
    logic [31:0]      rd_mux;
    logic [31:0]      rdata_q;
    logic             unused_wbits;

    assign wr_ctrl  = reg_we && reg_addr == A_CTRL;
    assign wr_attr  = reg_we && reg_addr == A_ATTR;
    assign wr_key   = reg_we && reg_addr == A_KEY;
    assign load_req = reg_wdata[CTRL_LOAD_BIT];

    assign tbl_rd_idx   = reg_wdata[IDX_W-1:0];
    assign tbl_wr_idx   = reg_wdata[IDX_W-1:0];
    assign tbl_wr_en    = wr_ctrl && !load_req;
    assign tbl_wr_entry = stage_q;

    assign unused_wbits = ^{reg_wdata[30:ATTR_DOM_LSB+DOM_W], reg_wdata[7:SID_W]};

    // Purpose: remember the last index and direction written to control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_idx_q  <= '0;
            ctrl_load_q <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_idx_q  <= reg_wdata[IDX_W-1:0];
            ctrl_load_q <= load_req;
        end
    end

    // Purpose: update staging from software writes or from an entry load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr_ctrl && load_req) begin
            stage_q <= tbl_rd_entry;
        end else if (wr_attr) begin
            stage_q.vld <= reg_wdata[ATTR_VLD_BIT];
            stage_q.dom <= reg_wdata[ATTR_DOM_LSB +: DOM_W];
            stage_q.sid <= reg_wdata[ATTR_SID_LSB +: SID_W];
        end else if (wr_key) begin
            stage_q.rid <= reg_wdata[KEY_RID_LSB +: RID_W];
            stage_q.msk <= reg_wdata[KEY_MSK_LSB +: RID_W];
        end
    end

    // Purpose: assemble read data with unused bits at zero.
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            A_CTRL: begin
                rd_mux[IDX_W-1:0]    = ctrl_idx_q;
                rd_mux[CTRL_LOAD_BIT] = ctrl_load_q;
            end
            A_ATTR: begin
                rd_mux[ATTR_VLD_BIT]                = stage_q.vld;
                rd_mux[ATTR_DOM_LSB +: DOM_W]       = stage_q.dom;
                rd_mux[ATTR_SID_LSB +: SID_W]       = stage_q.sid;
            end
            A_KEY: begin
                rd_mux[KEY_RID_LSB +: RID_W] = stage_q.rid;
                rd_mux[KEY_MSK_LSB +: RID_W] = stage_q.msk;
            end
            default: rd_mux = '0;
        endcase
    end

    // Purpose: register read data; zero when no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= reg_re ? rd_mux : '0;
    end

    assign reg_rdata = rdata_q;

    p_commit_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !load_req) |=> (!ctrl_load_q && ctrl_idx_q == $past(reg_wdata[IDX_W-1:0])))
        else $error("p_commit_ctrl_r3");

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == A_ATTR) |=> (reg_rdata[30:11] == '0 && reg_rdata[7:6] == '0))
        else $error("p_rsvd_zero_r2");

    p_bad_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == 2'd3) |=> reg_rdata == '0)
        else $error("p_bad_addr_r10");

    p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> reg_rdata == '0)
        else $error("p_idle_rdata_r11");

endmodule

// File: rtl/rid_sid_xlate.sv
// Module: top of the requester-ID to stream-ID translation table.
// Joins the register front end, the entry storage and the matcher.
// Assumes: one register access per cycle; lk_rid sampled every cycle.
module rid_sid_xlate
    import rsx_pkg::*;
#(
    parameter  int NUM_ENTRIES = 32,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_re,
    output logic [31:0]       reg_rdata,
    input  logic [RID_W-1:0]  lk_rid,
    output logic              lk_hit,
    output logic [SID_W-1:0]  lk_sid,
    output logic [DOM_W-1:0]  lk_dom
);

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    rsx_entry_t       wr_entry, rd_entry;
    rsx_entry_t       entries [NUM_ENTRIES];

    rsx_regs #(.NUM_ENTRIES(NUM_ENTRIES)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_re       (reg_re),
        .reg_rdata    (reg_rdata),
        .tbl_wr_en    (wr_en),
        .tbl_wr_idx   (wr_idx),
        .tbl_wr_entry (wr_entry),
        .tbl_rd_idx   (rd_idx),
        .tbl_rd_entry (rd_entry)
    );

    rsx_table #(.NUM_ENTRIES(NUM_ENTRIES)) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_entry  (wr_entry),
        .rd_idx    (rd_idx),
        .rd_entry  (rd_entry),
        .entries_o (entries)
    );

    rsx_match #(.NUM_ENTRIES(NUM_ENTRIES)) match_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_rid  (lk_rid),
        .entries (entries),
        .hit_o   (lk_hit),
        .sid_o   (lk_sid),
        .dom_o   (lk_dom)
    );

endmodule

// File: tb/rid_sid_xlate_tb_top.sv
// Bench: programs overlapping entries, walks a lookup vector table, then
// runs directed checks on reset, read-back, invalidation and timing.
module rid_sid_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic [15:0] lk_rid = '0;
    logic        lk_hit;
    logic [5:0]  lk_sid;
    logic [2:0]  lk_dom;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rid_sid_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .lk_rid(lk_rid), .lk_hit(lk_hit), .lk_sid(lk_sid), .lk_dom(lk_dom)
    );

    // Vector: {rid[15:0], hit, dom[2:0], sid[5:0], 6'b0}
    localparam int NV = 10;
    localparam logic [31:0] VEC [NV] = '{
        {16'h0100, 1'b1, 3'd2, 6'h15, 6'd0},   // R5 exact
        {16'h0101, 1'b0, 3'd0, 6'h00, 6'd0},   // R5 exact mask rejects neighbour
        {16'h0200, 1'b1, 3'd5, 6'h2A, 6'd0},   // R5 bus-wide mask
        {16'h02FF, 1'b1, 3'd5, 6'h2A, 6'd0},   // R5 bus-wide mask upper edge
        {16'h0208, 1'b1, 3'd5, 6'h2A, 6'd0},   // R6 lower index wins
        {16'h030C, 1'b1, 3'd3, 6'h07, 6'd0},   // R5 range of eight
        {16'h0307, 1'b0, 3'd0, 6'h00, 6'd0},   // R7 below range
        {16'h0310, 1'b0, 3'd0, 6'h00, 6'd0},   // R7 above range
        {16'h0400, 1'b0, 3'd0, 6'h00, 6'd0},   // R5 invalid entry ignored
        {16'h0000, 1'b0, 3'd0, 6'h00, 6'd0}    // R7 zero rid misses
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic prog(input int idx, input logic [31:0] attr, input logic [31:0] key);
        reg_wr(2'd1, attr);
        reg_wr(2'd2, key);
        reg_wr(2'd0, 32'(idx));
    endtask

    task automatic look(input logic [15:0] rid, output logic [31:0] res);
        @(negedge clk);
        lk_rid = rid;
        @(negedge clk);
        res = {16'h0, 1'b0, lk_hit, lk_dom, lk_sid, 4'h0};
    endtask

    function automatic logic [31:0] exp_res(input logic [31:0] v);
        return {16'h0, 1'b0, v[15], v[14:12], v[11:6], 4'h0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        look(16'h0000, r);  check("R1 lookup after reset", r, 32'h0);
        reg_rd(2'd0, r);    check("R1 ctrl after reset", r, 32'h0);
        reg_rd(2'd1, r);    check("R1 attr after reset", r, 32'h0);
        reg_rd(2'd2, r);    check("R1 key after reset", r, 32'h0);

        // Program entries (R3)
        prog(3,  32'h8000_0215, 32'h0100_FFFF);
        prog(5,  32'h8000_052A, 32'h0200_FF00);
        prog(7,  32'h8000_013F, 32'h0208_FFFF);
        prog(10, 32'h8000_0307, 32'h0308_FFF8);
        prog(1,  32'h0000_0409, 32'h0400_FFFF);
        reg_rd(2'd0, r);    check("R3 ctrl readback after commit", r, 32'h0000_0001);

        // Vector walk (R5, R6, R7)
        for (int i = 0; i < NV; i++) begin
            look(VEC[i][31:16], r);
            check($sformatf("R5/R6/R7 vector %0d", i), r, exp_res(VEC[i]));
        end

        // R4: load entry 5 into staging
        reg_wr(2'd0, 32'h0001_0005);
        reg_rd(2'd1, r);    check("R4 attr of entry 5", r, 32'h8000_052A);
        reg_rd(2'd2, r);    check("R10 key of entry 5", r, 32'h0200_FF00);
        reg_rd(2'd0, r);    check("R4 ctrl shows load flag", r, 32'h0001_0005);

        // R2: unused attribute bits read zero
        reg_wr(2'd1, 32'hFFFF_FFFF);
        reg_rd(2'd1, r);    check("R2 attr unused bits", r, 32'h8000_073F);

        // R10: address 3 ignored
        reg_wr(2'd2, 32'h1234_5678);
        reg_wr(2'd3, 32'hFFFF_FFFF);
        reg_rd(2'd3, r);    check("R10 addr3 reads zero", r, 32'h0);
        reg_rd(2'd2, r);    check("R10 key unchanged by addr3", r, 32'h1234_5678);
        reg_rd(2'd1, r);    check("R10 attr unchanged by addr3", r, 32'h8000_073F);

        // R11: no read -> zero
        @(negedge clk);
        check("R11 rdata idle", reg_rdata, 32'h0);

        // R9: invalidate entry 5
        prog(5, 32'h0, 32'h0);
        look(16'h0208, r);  check("R9 falls to entry 7", r, {16'h0, 1'b0, 1'b1, 3'd1, 6'h3F, 4'h0});
        look(16'h0200, r);  check("R9 former match misses", r, 32'h0);

        // R8: same-cycle commit is not seen; next cycle it is
        reg_wr(2'd1, 32'h8000_0411);
        reg_wr(2'd2, 32'h0500_FFFF);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 32'h0000_000C; reg_we = 1'b1; lk_rid = 16'h0500;
        @(negedge clk);
        reg_we = 1'b0;
        check("R8 same-cycle lookup sees old table", {31'h0, lk_hit}, 32'h0);
        @(negedge clk);
        check("R8 new entry visible next cycle",
              {16'h0, 1'b0, lk_hit, lk_dom, lk_sid, 4'h0},
              {16'h0, 1'b0, 1'b1, 3'd4, 6'h11, 4'h0});
        // R8: output lags the input by one clock
        @(negedge clk);
        lk_rid = 16'h0100;
        #5;
        check("R8 output before edge still old", {26'h0, lk_sid}, 32'h11);
        @(negedge clk);
        check("R8 output after edge", {26'h0, lk_sid}, 32'h15);

        // R1: reset clears the table again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(16'h0100, r);  check("R1 lookup after second reset", r, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule